// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between the integer pipeline and a data memory that is 32 bits wide and addressed by word. Each cycle it decodes the memory opcode and adds the base register to the sign-extended 16-bit immediate to form the effective address. It then issues the word address, and for stores it also issues per-byte write enables and the store data placed on the correct byte lanes. Byte lanes are big-endian: byte offset 0 is the most significant byte of the word. Every access must be aligned to its own size. An access that breaks this rule raises a misalign flag and never writes memory.

The memory is assumed to have a synchronous read port. The read word for a load therefore arrives one cycle after the address. The aligner registers the load's size, offset and extension mode, then uses them in the following cycle to pick the addressed byte or halfword out of the read word and extend it to 32 bits. Loads can issue back to back, one per cycle.

Top module: `lsu_be_aligner`

## Requirements
- R1: The effective address is base_i plus imm_i sign-extended to 32 bits, with wrap modulo 2^32. word_addr_o equals effective address bits 31..2 in every cycle.
- R2: Byte store (opcode 0x17) asserts exactly one byte enable. byte_en_o bit k gates wr_data_o bits 8k+7..8k, so offset 0 gives 4'b1000 and offset 3 gives 4'b0001. wr_data_o carries store bits 7..0 repeated in all four lanes.
- R3: Halfword store (opcode 0x1f) at offset 0 gives byte_en_o 4'b1100 and at offset 2 gives 4'b0011. wr_data_o carries store bits 15..0 repeated in both halves.
- R4: Aligned word store (opcode 0x2a) gives byte_en_o 4'b1111, and wr_data_o equals the store data unchanged.
- R5: misalign_o is 1 for a halfword access whose address bit 0 is set, and for a word access whose address bits 1..0 are not both zero. In that case byte_en_o is 0. A misaligned load returns 0 in the cycle that follows. Byte accesses are never misaligned.
- R6: For any opcode that is neither a load nor a store, byte_en_o is 0, misalign_o is 0 and wr_data_o is 0. For a load, wr_data_o is also 0.
- R7: ld_result_o is produced in the cycle after a load opcode, taken from rd_word_i in that cycle. A byte load takes bits 31-8k..24-8k for offset k. Opcode 0x0d sign-extends the byte and opcode 0x0e zero-extends it.
- R8: A halfword load takes bits 31..16 for offset 0 and bits 15..0 for offset 2. Opcode 0x11 sign-extends the halfword and opcode 0x13 zero-extends it.
- R9: Word load (opcode 0x14) returns rd_word_i unchanged in the following cycle.
- R10: ld_result_o is 0 while rst_n is low, and in any cycle that follows a non-load or a misaligned load. This includes a load that was still pending when reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Opcode of the current instruction |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Offset immediate, two's complement |
| st_data_i | input | 32 | Store source register value |
| rd_word_i | input | 32 | Memory read word, valid one cycle after a load address |
| word_addr_o | output | 30 | Word address to memory |
| byte_en_o | output | 4 | Per-lane write enables, bit 3 = most significant byte |
| wr_data_o | output | 32 | Lane-steered store data |
| ld_result_o | output | 32 | Extended load result, one cycle after the load |
| misalign_o | output | 1 | Current access breaks size alignment |

## Verification
The bench targets the corner cases of lane order and extension:
- A byte at offset 3 and a halfword at offset 2. A design that reverses the lanes to little-endian order would return the wrong byte and set the wrong enable bits.
- Sign bits at the exact boundaries: 0x7F against 0x80, and 0x7FFF against 0x8001. A design that confuses signed and unsigned extension would fill the upper bits incorrectly.
- A negative immediate that wraps the address through zero. A design that zero-extends the immediate would produce a wrong word address.
- Misaligned halfword and word stores. A design that fails to suppress writes would leave byte enables set.
- Back-to-back loads, and a reset that lands while a load is pending. A design that does not hold the offset for the returning data, or does not clear it on reset, would return stale bytes.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_LDB_S = 6'h0d;
  localparam logic [OP_W-1:0] OPC_LDB_U = 6'h0e;
  localparam logic [OP_W-1:0] OPC_LDH_S = 6'h11;
  localparam logic [OP_W-1:0] OPC_LDH_U = 6'h13;
  localparam logic [OP_W-1:0] OPC_LDW   = 6'h14;
  localparam logic [OP_W-1:0] OPC_STB   = 6'h17;
  localparam logic [OP_W-1:0] OPC_STH   = 6'h1f;
  localparam logic [OP_W-1:0] OPC_STW   = 6'h2a;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      sext;
    acc_size_e size;
  } acc_ctl_t;

  function automatic acc_ctl_t decode_op(input logic [OP_W-1:0] op);
    acc_ctl_t c;
    c.is_load  = 1'b0;
    c.is_store = 1'b0;
    c.sext     = 1'b0;
    c.size     = SZ_W;
    case (op)
      OPC_LDB_S: begin c.is_load = 1'b1; c.sext = 1'b1; c.size = SZ_B; end
      OPC_LDB_U: begin c.is_load = 1'b1; c.size = SZ_B; end
      OPC_LDH_S: begin c.is_load = 1'b1; c.sext = 1'b1; c.size = SZ_H; end
      OPC_LDH_U: begin c.is_load = 1'b1; c.size = SZ_H; end
      OPC_LDW:   begin c.is_load = 1'b1; c.size = SZ_W; end
      OPC_STB:   begin c.is_store = 1'b1; c.size = SZ_B; end
      OPC_STH:   begin c.is_store = 1'b1; c.size = SZ_H; end
      OPC_STW:   begin c.is_store = 1'b1; c.size = SZ_W; end
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_be_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sx;
  logic [OFF_W-1:0]  align_mask;

  assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign ea_o   = base_i + imm_sx;

  always_comb begin
    case (size_i)
      SZ_B:    align_mask = '0;
      SZ_H:    align_mask = {{(OFF_W-1){1'b0}}, 1'b1};
      default: align_mask = '1;
    endcase
  end

  assign misalign_o = |(ea_o[OFF_W-1:0] & align_mask);

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_be_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_ctl_t                       ctl_i,
  input  logic [$clog2(DATA_W/8)-1:0]    off_i,
  input  logic                           misalign_i,
  input  logic [DATA_W-1:0]              st_data_i,
  output logic [DATA_W/8-1:0]            be_o,
  output logic [DATA_W-1:0]              wdata_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(i);
    localparam logic [OFF_W-2:0] HALF_IDX = (OFF_W-1)'(i / 2);
    localparam int               HSRC     = 1 - (i % 2);
    localparam int               WSRC     = BYTES - 1 - i;

    logic       hit;
    logic [7:0] lane;

    always_comb begin
      case (ctl_i.size)
        SZ_B:    hit = (off_i == LANE_IDX);
        SZ_H:    hit = (off_i[OFF_W-1:1] == HALF_IDX);
        default: hit = 1'b1;
      endcase
    end

    always_comb begin
      case (ctl_i.size)
        SZ_B:    lane = st_data_i[7:0];
        SZ_H:    lane = st_data_i[8*HSRC +: 8];
        default: lane = st_data_i[8*WSRC +: 8];
      endcase
      if (!ctl_i.is_store) lane = '0;
    end

    assign be_o[BYTES-1-i]              = ctl_i.is_store & ~misalign_i & hit;
    assign wdata_o[DATA_W-1-8*i -: 8]   = lane;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_be_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  acc_ctl_t                       ctl_i,
  input  logic [$clog2(DATA_W/8)-1:0]    off_i,
  input  logic                           misalign_i,
  input  logic [DATA_W-1:0]              rd_word_i,
  output logic [DATA_W-1:0]              ld_result_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic             vld_d, vld_q;
  logic             sext_q;
  acc_size_e        size_q;
  logic [OFF_W-1:0] off_q;
  logic             cap_en;

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ext;
  int                sh;

  // next state
  assign vld_d  = ctl_i.is_load & ~misalign_i;
  assign cap_en = vld_d;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sext_q <= 1'b0;
      size_q <= SZ_W;
      off_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (cap_en) begin
        sext_q <= ctl_i.sext;
        size_q <= ctl_i.size;
        off_q  <= off_i;
      end
    end
  end

  // lane extraction and extension
  always_comb begin
    case (size_q)
      SZ_B:    sh = 8 * (BYTES - 1 - int'(off_q));
      SZ_H:    sh = 8 * (BYTES - 2 - int'(off_q));
      default: sh = 0;
    endcase
    shifted = rd_word_i >> sh;
    case (size_q)
      SZ_B:    ext = {{(DATA_W-8){sext_q & shifted[7]}}, shifted[7:0]};
      SZ_H:    ext = {{(DATA_W-16){sext_q & shifted[15]}}, shifted[15:0]};
      default: ext = shifted;
    endcase
  end

  assign ld_result_o = vld_q ? ext : '0;

  // R10
  ld_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_d |=> (ld_result_o == '0));

  // R7
  ld_byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && !ctl_i.sext && ctl_i.size == SZ_B) |=> (ld_result_o[DATA_W-1:8] == '0));

  // R8
  ld_half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && !ctl_i.sext && ctl_i.size == SZ_H) |=> (ld_result_o[DATA_W-1:16] == '0));

endmodule

// File: rtl/lsu_be_aligner.sv
module lsu_be_aligner
  import lsu_be_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [OP_W-1:0]               op_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [IMM_W-1:0]              imm_i,
  input  logic [DATA_W-1:0]             st_data_i,
  input  logic [DATA_W-1:0]             rd_word_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] word_addr_o,
  output logic [DATA_W/8-1:0]           byte_en_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic [DATA_W-1:0]             ld_result_o,
  output logic                          misalign_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  acc_ctl_t          ctl;
  logic [ADDR_W-1:0] ea;
  logic              mis_raw;
  logic              mis;

  assign ctl = decode_op(op_i);
  assign mis = (ctl.is_load | ctl.is_store) & mis_raw;

  lsu_addr_gen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .OFF_W  (OFF_W)
  ) u_addr (
    .base_i     (base_i),
    .imm_i      (imm_i),
    .size_i     (ctl.size),
    .ea_o       (ea),
    .misalign_o (mis_raw)
  );

  lsu_store_lane #(
    .DATA_W (DATA_W)
  ) u_store (
    .ctl_i      (ctl),
    .off_i      (ea[OFF_W-1:0]),
    .misalign_i (mis),
    .st_data_i  (st_data_i),
    .be_o       (byte_en_o),
    .wdata_o    (wr_data_o)
  );

  lsu_load_extract #(
    .DATA_W (DATA_W)
  ) u_load (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_i       (ctl),
    .off_i       (ea[OFF_W-1:0]),
    .misalign_i  (mis),
    .rd_word_i   (rd_word_i),
    .ld_result_o (ld_result_o)
  );

  assign word_addr_o = ea[ADDR_W-1:OFF_W];
  assign misalign_o  = mis;

  // R5
  misalign_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (byte_en_o == '0));

  // R2
  byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPC_STB) |-> ($countones(byte_en_o) == 1));

  // R4
  word_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPC_STW && !misalign_o) |-> (byte_en_o == '1 && wr_data_o == st_data_i));

  // R6
  idle_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.is_load && !ctl.is_store) |-> (byte_en_o == '0 && !misalign_o && wr_data_o == '0));

endmodule

// File: tb/lsu_be_aligner_tb_top.sv
module lsu_be_aligner_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [5:0]  op;
  logic [31:0] base;
  logic [15:0] imm;
  logic [31:0] sdata;
  logic [31:0] rword;
  logic [29:0] waddr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] ldres;
  logic        mis;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  lsu_be_aligner dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .base_i      (base),
    .imm_i       (imm),
    .st_data_i   (sdata),
    .rd_word_i   (rword),
    .word_addr_o (waddr),
    .byte_en_o   (be),
    .wr_data_o   (wdata),
    .ld_result_o (ldres),
    .misalign_o  (mis)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] imm;
    logic [31:0] sd;
    logic [31:0] rw;
    logic [29:0] wa;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        mis;
    logic [31:0] ld;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    // R7 byte loads, signed and unsigned, offsets 1, 0, 3
    '{6'h0d, 32'h1000, 16'h0001, 32'h0, 32'h11A23344, 30'h400, 4'h0, 32'h0, 1'b0, 32'hFFFFFFA2, 4'd7},
    '{6'h0e, 32'h1000, 16'h0001, 32'h0, 32'h11A23344, 30'h400, 4'h0, 32'h0, 1'b0, 32'h000000A2, 4'd7},
    '{6'h0d, 32'h2003, 16'hFFFD, 32'h0, 32'h7F800000, 30'h800, 4'h0, 32'h0, 1'b0, 32'h0000007F, 4'd7},
    '{6'h0d, 32'h3000, 16'h0003, 32'h0, 32'h00000080, 30'hC00, 4'h0, 32'h0, 1'b0, 32'hFFFFFF80, 4'd7},
    // R8 halfword loads
    '{6'h11, 32'h0100, 16'h0000, 32'h0, 32'h80011234, 30'h040, 4'h0, 32'h0, 1'b0, 32'hFFFF8001, 4'd8},
    '{6'h13, 32'h0100, 16'h0002, 32'h0, 32'h1234F00D, 30'h040, 4'h0, 32'h0, 1'b0, 32'h0000F00D, 4'd8},
    '{6'h11, 32'h0100, 16'h0002, 32'h0, 32'h12347FFF, 30'h040, 4'h0, 32'h0, 1'b0, 32'h00007FFF, 4'd8},
    // R9 word load with negative immediate
    '{6'h14, 32'h0010, 16'hFFF0, 32'h0, 32'hDEADBEEF, 30'h000, 4'h0, 32'h0, 1'b0, 32'hDEADBEEF, 4'd9},
    // R5 misaligned loads
    '{6'h11, 32'h0101, 16'h0000, 32'h0, 32'hFFFFFFFF, 30'h040, 4'h0, 32'h0, 1'b1, 32'h0, 4'd5},
    '{6'h14, 32'h0102, 16'h0000, 32'h0, 32'hFFFFFFFF, 30'h040, 4'h0, 32'h0, 1'b1, 32'h0, 4'd5},
    // R2 byte stores
    '{6'h17, 32'h0200, 16'h0000, 32'h123456AB, 32'hFFFFFFFF, 30'h080, 4'h8, 32'hABABABAB, 1'b0, 32'h0, 4'd2},
    '{6'h17, 32'h0200, 16'h0002, 32'h123456AB, 32'hFFFFFFFF, 30'h080, 4'h2, 32'hABABABAB, 1'b0, 32'h0, 4'd2},
    '{6'h17, 32'h0200, 16'h0003, 32'h123456AB, 32'hFFFFFFFF, 30'h080, 4'h1, 32'hABABABAB, 1'b0, 32'h0, 4'd2},
    // R3 halfword stores
    '{6'h1f, 32'h0200, 16'h0000, 32'hCAFEBEEF, 32'hFFFFFFFF, 30'h080, 4'hC, 32'hBEEFBEEF, 1'b0, 32'h0, 4'd3},
    '{6'h1f, 32'h0200, 16'h0002, 32'hCAFEBEEF, 32'hFFFFFFFF, 30'h080, 4'h3, 32'hBEEFBEEF, 1'b0, 32'h0, 4'd3},
    // R5 misaligned halfword store
    '{6'h1f, 32'h0200, 16'h0001, 32'hCAFEBEEF, 32'hFFFFFFFF, 30'h080, 4'h0, 32'hBEEFBEEF, 1'b1, 32'h0, 4'd5},
    // R4 word store crossing the sign boundary of the address
    '{6'h2a, 32'h7FFFFFFC, 16'h0004, 32'h01234567, 32'hFFFFFFFF, 30'h20000000, 4'hF, 32'h01234567, 1'b0, 32'h0, 4'd4},
    // R5 misaligned word store
    '{6'h2a, 32'h0203, 16'h0000, 32'h01234567, 32'hFFFFFFFF, 30'h080, 4'h0, 32'h01234567, 1'b1, 32'h0, 4'd5},
    // R6 non-memory opcodes
    '{6'h02, 32'h0203, 16'h0000, 32'h01234567, 32'hFFFFFFFF, 30'h080, 4'h0, 32'h0, 1'b0, 32'h0, 4'd6},
    '{6'h2b, 32'h0001, 16'h0001, 32'h01234567, 32'hFFFFFFFF, 30'h000, 4'h0, 32'h0, 1'b0, 32'h0, 4'd6},
    // R1 address wraps through zero
    '{6'h0e, 32'h0000, 16'hFFFF, 32'h0, 32'h000000C3, 30'h3FFFFFFF, 4'h0, 32'h0, 1'b0, 32'h000000C3, 4'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    op    = 6'h14;
    base  = '0;
    imm   = '0;
    sdata = '0;
    rword = 32'hA5A5A5A5;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state of the load result
    chk("R10", "ld_result in reset", ldres, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    op    = 6'h00;
    @(negedge clk);
    #1;
    // R10 first cycle after reset, previous op non-load
    chk("R10", "ld_result after reset", ldres, 32'h0);

    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", TBL[k].req);
      @(negedge clk);
      op    = TBL[k].op;
      base  = TBL[k].base;
      imm   = TBL[k].imm;
      sdata = TBL[k].sd;
      #1;
      chk(rq, "word_addr", 32'(waddr), 32'(TBL[k].wa));
      chk(rq, "byte_en", 32'(be), 32'(TBL[k].be));
      chk(rq, "wr_data", wdata, TBL[k].wd);
      chk(rq, "misalign", 32'(mis), 32'(TBL[k].mis));
      @(negedge clk);
      op    = 6'h00;
      rword = TBL[k].rw;
      #1;
      chk(rq, "ld_result", ldres, TBL[k].ld);
    end

    // R7 R8 back-to-back loads
    @(negedge clk);
    op = 6'h0d; base = 32'h1000; imm = 16'h0002;
    @(negedge clk);
    op = 6'h13; imm = 16'h0000; rword = 32'h00008000;
    #1;
    chk("R7", "pipelined byte load", ldres, 32'hFFFFFF80);
    @(negedge clk);
    op = 6'h00; rword = 32'h9ABC0000;
    #1;
    chk("R8", "pipelined half load", ldres, 32'h00009ABC);

    // R10 reset while a load is pending
    @(negedge clk);
    op = 6'h14; base = 32'h0; imm = 16'h0;
    @(negedge clk);
    rst_n = 1'b0;
    op    = 6'h00;
    rword = 32'hDEADBEEF;
    #1;
    chk("R10", "pending load cleared by reset", ldres, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10", "result after reset release", ldres, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule